// File: doc/BRIEF.md
# VLIW Execute-Packet Dispatcher

This block sits between instruction fetch and decode in a wide-issue core. It takes in one fetch packet at a time. A fetch packet is a wide word that holds `SLOTS` instruction slots of `IW` bits each. The block splits the fetch packet into execute packets and issues them one per cycle. Bit 0 of every instruction is a chain bit. When it is 1, the next slot belongs to the same execute packet. When it is 0, the packet ends at that slot. The highest slot always closes the packet, so an execute packet never reaches into the next fetch packet.

Each issued packet is presented on the output with every instruction kept in its original slot position. A valid mask marks the slots that belong to the packet, and all other slots are driven to zero. A flag marks the first packet taken from each fetch packet. Both the fetch side and the issue side use a valid/ready handshake. The block requests a new fetch packet only after the last execute packet of the current one has been issued. A synchronous flush drops whatever is held and returns the block to waiting for fetch.

Top module: `vliw_pkt_dispatch`

## Requirements
- R1: After a synchronous reset (`rst` high at a clock edge), `ep_valid` is 0, `ep_mask` and `ep_data` are all zero, and `fp_ready` is 1 while `flush` is low.
- R2: `fp_ready` is 1 exactly when no fetch packet is held and `flush` is low. A fetch packet is taken at a clock edge where both `fp_valid` and `fp_ready` are 1.
- R3: Slot i of a fetch packet is `fp_data[i*IW +: IW]`, and slot 0 comes first. The chain bit of a slot is bit 0 of its word. An execute packet runs from its start slot up to and including the first slot at or above it whose chain bit is 0.
- R4: Slot `SLOTS-1` ends the execute packet whatever its chain bit is. A fetch packet whose chain bits are all 1 therefore issues as a single packet covering every slot.
- R5: Every output slot carries the word from the same slot of the fetch packet. Slots outside `ep_mask` are zero. While `ep_valid` is 1, `ep_mask` is non-zero and its set bits form one contiguous run. While `ep_valid` is 0, `ep_mask` and `ep_data` are zero.
- R6: Each handshake on the issue side (`ep_valid` and `ep_ready` both 1) consumes exactly one execute packet. The next packet starts at the slot directly above the previous packet's highest slot, so no slot is skipped or issued twice.
- R7: While `ep_valid` is 1 and `ep_ready` is 0 (and `flush` is low), `ep_data`, `ep_mask` and `ep_first` stay the same in the next cycle.
- R8: After the handshake that issues the packet containing slot `SLOTS-1`, `ep_valid` is 0 in the next cycle and `fp_ready` returns to 1. The next fetch packet can be taken no earlier than that cycle.
- R9: `ep_first` is 1 on an issued packet exactly when that packet contains slot 0.
- R10: While `flush` is 1, `fp_ready` is 0 and any fetch packet on offer is ignored. In the cycle after a flush, `ep_valid` is 0, even when the held packet was only partly issued.
- R11: The first execute packet of a fetch packet is presented in the cycle right after the fetch packet is taken, with `ep_first` set to 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| flush | input | 1 | Synchronous discard of the held fetch packet |
| fp_valid | input | 1 | Fetch packet offered |
| fp_ready | output | 1 | Block can take a fetch packet |
| fp_data | input | SLOTS*IW | Fetch packet, slot i at bits i*IW +: IW |
| ep_valid | output | 1 | Execute packet presented |
| ep_ready | input | 1 | Consumer takes the execute packet |
| ep_data | output | SLOTS*IW | Instruction words in their original slots, unused slots zero |
| ep_mask | output | SLOTS | One bit per slot of the presented packet |
| ep_first | output | 1 | Packet is the first one from its fetch packet |

## Verification
The bench builds the block with its defaults, eight slots of 32 bits. With these values every packet length from one to eight can be produced. So can the full-width case where all chain bits are 1, and the case where the top slot carries chain bit 1 yet still closes a packet. Random chain bits, random back-pressure and random flushes together reach stalls on every start slot, as well as flushes that land in the middle of a fetch packet. The reference model also checks the fetch-ready timing on every cycle, so any early or late fetch request shows up directly.

// File: rtl/dispatch_pkg.sv
package dispatch_pkg;
  typedef enum logic {
    HOLD_EMPTY = 1'b0,
    HOLD_FULL  = 1'b1
  } hold_e;
endpackage

// File: rtl/dp_fetch_hold.sv
module dp_fetch_hold
  import dispatch_pkg::*;
#(
  parameter int SLOTS = 8,
  parameter int IW    = 32,
  localparam int IDXW = $clog2(SLOTS),
  localparam int FPW  = SLOTS * IW
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            flush,
  input  logic            fp_valid,
  input  logic [FPW-1:0]  fp_data,
  input  logic            issue_fire,
  input  logic            issue_last,
  input  logic [IDXW-1:0] next_start,
  output logic            fp_ready,
  output logic            accept_fire,
  output logic            held_valid,
  output logic [FPW-1:0]  held_data,
  output logic [IDXW-1:0] start_idx,
  output logic            first_flag
);
  hold_e state_q;

  assign fp_ready    = (state_q == HOLD_EMPTY) && !flush;
  assign accept_fire = fp_valid && fp_ready;
  assign held_valid  = (state_q == HOLD_FULL);

  always_ff @(posedge clk) begin
    if (rst || flush) begin
      state_q    <= HOLD_EMPTY;
      held_data  <= '0;
      start_idx  <= '0;
      first_flag <= 1'b0;
    end else begin
      case (state_q)
        HOLD_EMPTY: begin
          if (accept_fire) begin
            state_q    <= HOLD_FULL;
            held_data  <= fp_data;
            start_idx  <= '0;
            first_flag <= 1'b1;
          end
        end
        HOLD_FULL: begin
          if (issue_fire) begin
            if (issue_last) begin
              state_q    <= HOLD_EMPTY;
              first_flag <= 1'b0;
            end else begin
              start_idx  <= next_start;
              first_flag <= 1'b0;
            end
          end
        end
        default: state_q <= HOLD_EMPTY;
      endcase
    end
  end
endmodule

// File: rtl/dp_chain_scan.sv
module dp_chain_scan #(
  parameter int SLOTS = 8,
  localparam int IDXW = $clog2(SLOTS)
) (
  input  logic [SLOTS-1:0] chain_bits,
  input  logic [IDXW-1:0]  start_idx,
  output logic [SLOTS-1:0] pkt_mask,
  output logic [IDXW-1:0]  end_idx,
  output logic             ends_fetch,
  output logic [IDXW-1:0]  next_start
);
  localparam logic [IDXW-1:0] TOP = IDXW'(SLOTS - 1);

  // First slot at or above lo whose chain bit is clear; the top slot always closes.
  function automatic logic [IDXW-1:0] find_close(input logic [SLOTS-1:0] ch,
                                                 input logic [IDXW-1:0]  lo);
    logic [IDXW-1:0] e;
    logic            hit;
    e   = TOP;
    hit = 1'b0;
    for (int k = 0; k < SLOTS; k++) begin
      if (!hit && (k >= int'(lo)) && !ch[k]) begin
        e   = IDXW'(k);
        hit = 1'b1;
      end
    end
    return e;
  endfunction

  function automatic logic [SLOTS-1:0] span(input logic [IDXW-1:0] lo,
                                            input logic [IDXW-1:0] hi);
    logic [SLOTS-1:0] m;
    for (int k = 0; k < SLOTS; k++) m[k] = (k >= int'(lo)) && (k <= int'(hi));
    return m;
  endfunction

  always_comb begin
    end_idx    = find_close(chain_bits, start_idx);
    pkt_mask   = span(start_idx, end_idx);
    ends_fetch = (end_idx == TOP);
    next_start = end_idx + IDXW'(1);
  end
endmodule

// File: rtl/dp_issue_gate.sv
module dp_issue_gate #(
  parameter int SLOTS = 8,
  parameter int IW    = 32,
  localparam int FPW  = SLOTS * IW
) (
  input  logic             held_valid,
  input  logic [FPW-1:0]   held_data,
  input  logic [SLOTS-1:0] pkt_mask,
  input  logic             first_flag,
  output logic             ep_valid,
  output logic [FPW-1:0]   ep_data,
  output logic [SLOTS-1:0] ep_mask,
  output logic             ep_first
);
  assign ep_valid = held_valid;
  assign ep_first = held_valid && first_flag;
  assign ep_mask  = held_valid ? pkt_mask : '0;

  for (genvar s = 0; s < SLOTS; s++) begin : g_slot
    assign ep_data[s*IW +: IW] = ep_mask[s] ? held_data[s*IW +: IW] : '0;
  end
endmodule

// File: rtl/vliw_pkt_dispatch.sv
module vliw_pkt_dispatch #(
  parameter int SLOTS = 8,
  parameter int IW    = 32,
  localparam int IDXW = $clog2(SLOTS),
  localparam int FPW  = SLOTS * IW
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             flush,
  input  logic             fp_valid,
  output logic             fp_ready,
  input  logic [FPW-1:0]   fp_data,
  output logic             ep_valid,
  input  logic             ep_ready,
  output logic [FPW-1:0]   ep_data,
  output logic [SLOTS-1:0] ep_mask,
  output logic             ep_first
);
  logic             accept_fire;
  logic             issue_fire;
  logic             issue_last;
  logic             held_valid;
  logic [FPW-1:0]   held_data;
  logic [IDXW-1:0]  start_idx;
  logic             first_flag;
  logic [SLOTS-1:0] chain_bits;
  logic [SLOTS-1:0] pkt_mask;
  logic [IDXW-1:0]  end_idx;
  logic             ends_fetch;
  logic [IDXW-1:0]  next_start;

  for (genvar s = 0; s < SLOTS; s++) begin : g_chain
    assign chain_bits[s] = held_data[s*IW];
  end

  assign issue_fire = ep_valid && ep_ready;
  assign issue_last = issue_fire && ends_fetch;

  dp_fetch_hold #(.SLOTS(SLOTS), .IW(IW)) u_hold (
    .clk        (clk),
    .rst        (rst),
    .flush      (flush),
    .fp_valid   (fp_valid),
    .fp_data    (fp_data),
    .issue_fire (issue_fire),
    .issue_last (issue_last),
    .next_start (next_start),
    .fp_ready   (fp_ready),
    .accept_fire(accept_fire),
    .held_valid (held_valid),
    .held_data  (held_data),
    .start_idx  (start_idx),
    .first_flag (first_flag)
  );

  dp_chain_scan #(.SLOTS(SLOTS)) u_scan (
    .chain_bits(chain_bits),
    .start_idx (start_idx),
    .pkt_mask  (pkt_mask),
    .end_idx   (end_idx),
    .ends_fetch(ends_fetch),
    .next_start(next_start)
  );

  dp_issue_gate #(.SLOTS(SLOTS), .IW(IW)) u_gate (
    .held_valid(held_valid),
    .held_data (held_data),
    .pkt_mask  (pkt_mask),
    .first_flag(first_flag),
    .ep_valid  (ep_valid),
    .ep_data   (ep_data),
    .ep_mask   (ep_mask),
    .ep_first  (ep_first)
  );
endmodule

// File: rtl/dp_checker.sv
module dp_checker #(
  parameter int SLOTS = 8,
  parameter int IW    = 32,
  localparam int FPW  = SLOTS * IW
) (
  input logic             clk,
  input logic             rst,
  input logic             flush,
  input logic             fp_valid,
  input logic             fp_ready,
  input logic [IW-1:0]    fp_slot0,
  input logic             ep_valid,
  input logic             ep_ready,
  input logic [FPW-1:0]   ep_data,
  input logic [SLOTS-1:0] ep_mask,
  input logic             ep_first,
  input logic             accept_fire,
  input logic             issue_fire
);
  logic [SLOTS-1:0] out_chain;
  logic [FPW-1:0]   mask_wide;
  logic [SLOTS-1:0] lowbit;
  logic [SLOTS-1:0] topmost;
  logic [SLOTS-1:0] inner;
  logic [SLOTS-1:0] top_slot;

  for (genvar s = 0; s < SLOTS; s++) begin : g_x
    assign out_chain[s]           = ep_data[s*IW];
    assign mask_wide[s*IW +: IW]  = {IW{ep_mask[s]}};
  end

  assign lowbit   = ep_mask & (~ep_mask + SLOTS'(1));
  assign topmost  = ep_mask & ~(ep_mask >> 1);
  assign inner    = ep_mask & (ep_mask >> 1);
  assign top_slot = SLOTS'(1) << (SLOTS - 1);

  assert_idle_after_reset_R1: assert property (@(posedge clk)
    rst |=> (!ep_valid && ep_mask == '0));

  assert_ready_only_empty_R2: assert property (@(posedge clk) disable iff (rst)
    fp_ready |-> !ep_valid);

  assert_chain_inside_R3: assert property (@(posedge clk) disable iff (rst)
    ep_valid |-> ((inner & ~out_chain) == '0));

  assert_close_rule_R4: assert property (@(posedge clk) disable iff (rst)
    ep_valid |-> ((topmost & out_chain & ~top_slot) == '0));

  assert_mask_contig_R5: assert property (@(posedge clk) disable iff (rst)
    ep_valid |-> (ep_mask != '0 && ((ep_mask + lowbit) & ep_mask) == '0));

  assert_unmasked_zero_R5: assert property (@(posedge clk) disable iff (rst)
    (ep_data & ~mask_wide) == '0);

  assert_next_start_R6: assert property (@(posedge clk) disable iff (rst)
    (issue_fire && !ep_mask[SLOTS-1] && !flush) |=>
      (ep_valid && lowbit == ($past(topmost) << 1)));

  assert_stall_hold_R7: assert property (@(posedge clk) disable iff (rst)
    (ep_valid && !ep_ready && !flush) |=>
      (ep_valid && $stable(ep_data) && $stable(ep_mask) && $stable(ep_first)));

  assert_last_drains_R8: assert property (@(posedge clk) disable iff (rst)
    (issue_fire && ep_mask[SLOTS-1]) |=> !ep_valid);

  assert_first_flag_R9: assert property (@(posedge clk) disable iff (rst)
    ep_valid |-> (ep_first == ep_mask[0]));

  assert_flush_ready_R10: assert property (@(posedge clk) disable iff (rst)
    flush |-> !fp_ready);

  assert_flush_drop_R10: assert property (@(posedge clk) disable iff (rst)
    flush |=> !ep_valid);

  assert_accept_issue_R11: assert property (@(posedge clk) disable iff (rst)
    (fp_valid && accept_fire) |=>
      (ep_valid && ep_first && ep_data[IW-1:0] == $past(fp_slot0)));
endmodule

bind vliw_pkt_dispatch dp_checker #(.SLOTS(SLOTS), .IW(IW)) u_chk (
  .clk        (clk),
  .rst        (rst),
  .flush      (flush),
  .fp_valid   (fp_valid),
  .fp_ready   (fp_ready),
  .fp_slot0   (fp_data[IW-1:0]),
  .ep_valid   (ep_valid),
  .ep_ready   (ep_ready),
  .ep_data    (ep_data),
  .ep_mask    (ep_mask),
  .ep_first   (ep_first),
  .accept_fire(accept_fire),
  .issue_fire (issue_fire)
);

// File: tb/sim_vliw_pkt_dispatch.sv
`timescale 1ns/1ps
module sim_vliw_pkt_dispatch;
  localparam int SLOTS = 8;
  localparam int IW    = 32;
  localparam int FPW   = SLOTS * IW;

  logic             clk = 1'b0;
  logic             rst = 1'b1;
  logic             flush = 1'b0;
  logic             fp_valid = 1'b0;
  logic             fp_ready;
  logic [FPW-1:0]   fp_data = '0;
  logic             ep_valid;
  logic             ep_ready = 1'b0;
  logic [FPW-1:0]   ep_data;
  logic [SLOTS-1:0] ep_mask;
  logic             ep_first;

  always #2.5 clk = ~clk;

  vliw_pkt_dispatch #(.SLOTS(SLOTS), .IW(IW)) u0 (
    .clk(clk), .rst(rst), .flush(flush), .fp_valid(fp_valid), .fp_ready(fp_ready),
    .fp_data(fp_data), .ep_valid(ep_valid), .ep_ready(ep_ready), .ep_data(ep_data),
    .ep_mask(ep_mask), .ep_first(ep_first)
  );

  // behavioural reference state
  bit          m_busy = 0;
  logic [IW-1:0] m_word [SLOTS];
  int          m_pos = 0;
  bit          m_first = 0;
  int          total = 0;
  int          bad = 0;
  bit          done = 0;

  task automatic chk(input string ctx, input string what,
                     input logic [FPW-1:0] act, input logic [FPW-1:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s %s actual=%h expected=%h", what, ctx, act, exp);
    end
  endtask

  function automatic logic [FPW-1:0] make_pkt(input int mode);
    logic [FPW-1:0] v;
    for (int s = 0; s < SLOTS; s++) begin
      logic [IW-1:0] w;
      w = $urandom;
      case (mode)
        0: w[0] = 1'b0;
        1: w[0] = 1'b1;
        2: w[0] = (s != 3);
        default: w[0] = $urandom_range(0, 1);
      endcase
      v[s*IW +: IW] = w;
    end
    return v;
  endfunction

  task automatic do_reset();
    @(negedge clk);
    rst = 1'b1; flush = 1'b0; fp_valid = 1'b0; ep_ready = 1'b0;
    repeat (2) @(negedge clk);
    rst = 1'b0;
    m_busy = 0; m_pos = 0; m_first = 0;
  endtask

  task automatic run_cycle(input string ctx, input bit fl, input bit fv,
                           input logic [FPW-1:0] fd, input bit er);
    int e;
    logic [SLOTS-1:0] xm;
    logic [FPW-1:0]   xd;
    @(negedge clk);
    flush = fl; fp_valid = fv; fp_data = fd; ep_ready = er;
    #1;
    xm = '0; xd = '0; e = m_pos;
    if (m_busy) begin
      while (e < SLOTS - 1 && m_word[e][0]) e++;
      for (int s = m_pos; s <= e; s++) begin
        xm[s] = 1'b1;
        xd[s*IW +: IW] = m_word[s];
      end
    end
    chk(ctx, "R2 fp_ready", FPW'(fp_ready), FPW'(!m_busy && !fl));
    chk(ctx, "R8 ep_valid", FPW'(ep_valid), FPW'(m_busy));
    chk(ctx, "R3 ep_mask",  FPW'(ep_mask),  FPW'(xm));
    chk(ctx, "R5 ep_data",  ep_data,        xd);
    chk(ctx, "R9 ep_first", FPW'(ep_first), FPW'(m_busy && m_first));
    // advance the model as the coming edge will
    if (fl) begin
      m_busy = 0;
    end else if (m_busy) begin
      if (er) begin
        if (e == SLOTS - 1) m_busy = 0;
        else begin m_pos = e + 1; m_first = 0; end
      end
    end else if (fv) begin
      for (int s = 0; s < SLOTS; s++) m_word[s] = fd[s*IW +: IW];
      m_busy = 1; m_pos = 0; m_first = 1;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog expired");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    do_reset();
    run_cycle("R1", 0, 0, '0, 1);                 // idle after reset
    // every slot its own packet
    run_cycle("R11", 0, 1, make_pkt(0), 1);
    for (int i = 0; i < 8; i++) run_cycle("R6", 0, 0, '0, 1);
    run_cycle("R8", 0, 1, make_pkt(0), 0);
    for (int i = 0; i < 10; i++) run_cycle("R8", 0, 0, '0, 1);
    // all chain bits set: one eight-wide packet
    run_cycle("R4", 0, 1, make_pkt(1), 1);
    for (int i = 0; i < 4; i++) run_cycle("R4", 0, 1, make_pkt(1), 1);
    // break at slot 3, top slot chained, stalls in between
    run_cycle("R7", 0, 1, make_pkt(2), 1);
    for (int i = 0; i < 8; i++) run_cycle("R7", 0, 0, '0, i[0]);
    // flush in the middle of a fetch packet, with another packet offered
    run_cycle("R10", 0, 1, make_pkt(0), 1);
    run_cycle("R10", 0, 0, '0, 1);
    run_cycle("R10", 0, 0, '0, 1);
    run_cycle("R10", 1, 1, make_pkt(1), 1);
    run_cycle("R10", 0, 0, '0, 1);
    run_cycle("R10", 0, 0, '0, 1);
    // reset while a packet is held
    run_cycle("R1", 0, 1, make_pkt(3), 0);
    run_cycle("R1", 0, 0, '0, 0);
    do_reset();
    run_cycle("R1", 0, 0, '0, 1);
    // random mix
    for (int i = 0; i < 3000; i++) begin
      run_cycle("R3", ($urandom_range(0, 39) == 0), ($urandom_range(0, 3) != 0),
                make_pkt($urandom_range(0, 3)), ($urandom_range(0, 2) != 0));
    end
    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule